// File: doc/BRIEF.md
# Planar Video Memory Write Datapath

This block is the write and latch path of a four-plane video memory. Each plane is a byte-wide RAM. All four planes share one offset, so one host byte address selects four bytes, one in each plane. On a host write, the host byte is transformed once per plane, under control registers that software loads through a small register-write port. The four results are then stored at the addressed offset in the same cycle.

The transform has four write modes:
- **Direct (0):** rotate the host byte, optionally substitute the set/reset value, apply a logic operation against the latched byte, then merge through the bit mask.
- **Latch copy (1):** store the latched bytes unchanged.
- **Expand (2):** replicate one host bit to all eight bits, apply the logic operation, then merge through the bit mask.
- **Masked fill (3):** write the set/reset value through a mask formed by ANDing the register bit mask with the rotated host byte.

A host read fetches the four bytes at an offset and captures them in four latch registers. Later writes merge against these latches. The read returns the byte of one plane, chosen by a register.

Reads use a small access state machine with two states:
- **ST_IDLE:** accepts host reads and writes.
- **ST_LOAD:** lasts one cycle. The RAM output is valid and presented to the host, and the latches are loaded at its closing edge.

Transitions:
- **ST_IDLE → ST_LOAD:** taken on a host read.
- **ST_LOAD → ST_IDLE:** always taken after one cycle.
- **ST_IDLE → ST_IDLE:** taken on a write or on no access.

Top module: `vplane_write_unit`

## Requirements
- R1: After reset the latch registers hold 0x00, `host_rvalid` is 0 and `host_rdata` is 0x00.
- R2: In write mode 1 each plane stores its own latch byte, and the host byte has no effect.
- R3: In write modes 0 and 3 the host byte is rotated right by the rotate count (0..7), with bits leaving bit 0 re-entering at bit 7.
- R4: In write mode 2, plane p takes host bit p replicated to 0xFF or 0x00.
- R5: In write mode 0, a plane whose enable-substitute bit is 1 uses its set/reset bit replicated to 8 bits in place of the rotated byte.
- R6: In modes 0 and 2, the logic select combines the data with the plane's latch byte as follows: 0 passes the data, 1 ANDs, 2 ORs and 3 XORs.
- R7: In write mode 3, the data is the plane's set/reset bit replicated, the effective mask is the bit mask AND the rotated host byte, and no logic operation is applied.
- R8: Each stored byte takes data bits where the effective mask is 1 and latch bits where it is 0. In modes 0 and 2 the effective mask is the bit mask register, so a mask of 0x00 leaves the latch byte.
- R9: A host read loads all four latches from the addressed offset of the four planes, at the end of the cycle after the read request.
- R10: `host_rvalid` is 1 exactly in the cycle after a read request. In that cycle `host_rdata` is the byte of the plane named by the read-select register, as it stood when the read was requested.
- R11: A host write updates all four planes at its offset in one cycle and leaves the latches unchanged.
- R12: The register map is as follows:
  - address 0 holds the write mode in bits 1:0;
  - address 1 holds the rotate count in bits 2:0 and the logic select in bits 4:3;
  - address 2 holds the set/reset nibble (bit p for plane p);
  - address 3 holds the enable-substitute nibble;
  - address 4 holds the bit mask;
  - address 5 holds the read-select in bits 1:0.

  Register writes take effect on the next cycle, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 3 | Control register address |
| cfg_wdata | input | 8 | Control register write data |
| host_wr | input | 1 | Host byte write request |
| host_rd | input | 1 | Host byte read request |
| host_addr | input | ADDR_W | Plane offset for the host access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte of the selected plane, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The assertions assume that the host never requests a read and a write in the same cycle. They also assume that no host access is requested in the ST_LOAD cycle that follows a read, because a write there would merge against latches that are in the middle of being loaded. The bench keeps within these rules by structure: every access task drives its request for exactly one cycle. A read task also waits out the load cycle before returning, so the next request always lands in ST_IDLE. Every offset is written once before it is first read, so no comparison meets an uninitialised RAM byte.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    localparam int BYTE_W     = 8;
    localparam int NUM_PLANES = 4;
    localparam int ROT_W      = $clog2(BYTE_W);
    localparam int SEL_W      = $clog2(NUM_PLANES);
    localparam int CFG_AW     = 3;

    // Control register addresses
    localparam logic [CFG_AW-1:0] CFG_MODE   = 3'd0;
    localparam logic [CFG_AW-1:0] CFG_FUNC   = 3'd1;
    localparam logic [CFG_AW-1:0] CFG_SETRES = 3'd2;
    localparam logic [CFG_AW-1:0] CFG_SUBST  = 3'd3;
    localparam logic [CFG_AW-1:0] CFG_MASK   = 3'd4;
    localparam logic [CFG_AW-1:0] CFG_RDSEL  = 3'd5;

    typedef enum logic [1:0] {
        WM_DIRECT      = 2'd0,
        WM_LATCH_COPY  = 2'd1,
        WM_EXPAND      = 2'd2,
        WM_MASKED_FILL = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        LOP_PASS = 2'd0,
        LOP_AND  = 2'd1,
        LOP_OR   = 2'd2,
        LOP_XOR  = 2'd3
    } lop_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } acc_state_e;

    typedef struct packed {
        wmode_e                  mode;
        logic [ROT_W-1:0]        rot;
        lop_e                    lop;
        logic [NUM_PLANES-1:0]   setres;
        logic [NUM_PLANES-1:0]   subst_en;
        logic [BYTE_W-1:0]       mask;
        logic [SEL_W-1:0]        rdsel;
    } ctrl_t;

endpackage

// File: rtl/vpw_ctrl_regs.sv
module vpw_ctrl_regs
    import vpw_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [BYTE_W-1:0]     cfg_wdata,
    output ctrl_t                 ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_MODE: begin
                    ctrl_q.mode <= wmode_e'(cfg_wdata[1:0]);
                end
                CFG_FUNC: begin
                    ctrl_q.rot <= cfg_wdata[ROT_W-1:0];
                    ctrl_q.lop <= lop_e'(cfg_wdata[4:3]);
                end
                CFG_SETRES: begin
                    ctrl_q.setres <= cfg_wdata[NUM_PLANES-1:0];
                end
                CFG_SUBST: begin
                    ctrl_q.subst_en <= cfg_wdata[NUM_PLANES-1:0];
                end
                CFG_MASK: begin
                    ctrl_q.mask <= cfg_wdata;
                end
                CFG_RDSEL: begin
                    ctrl_q.rdsel <= cfg_wdata[SEL_W-1:0];
                end
                default: begin
                    // unmapped addresses leave every register unchanged
                end
            endcase
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/vpw_plane_lane.sv
module vpw_plane_lane
    import vpw_pkg::*;
#(
    parameter int PLANE = 0
)(
    input  wmode_e               mode,
    input  logic [ROT_W-1:0]     rot,
    input  lop_e                 lop,
    input  logic                 setres_bit,
    input  logic                 subst_bit,
    input  logic [BYTE_W-1:0]    mask,
    input  logic [BYTE_W-1:0]    host_byte,
    input  logic [BYTE_W-1:0]    latch_byte,
    output logic [BYTE_W-1:0]    plane_byte
);

    logic [BYTE_W-1:0] rotated;
    logic [BYTE_W-1:0] fill;
    logic [BYTE_W-1:0] expanded;
    logic [BYTE_W-1:0] src;
    logic [BYTE_W-1:0] alu_out;
    logic [BYTE_W-1:0] eff_mask;

    // Right rotate: output bit i comes from input bit (i + rot) mod 8
    always_comb begin
        for (int i = 0; i < BYTE_W; i++) begin
            logic [ROT_W-1:0] idx;
            idx = ROT_W'(i) + rot;
            rotated[i] = host_byte[idx];
        end
    end

    assign fill     = {BYTE_W{setres_bit}};
    assign expanded = {BYTE_W{host_byte[PLANE]}};

    // Source selection per write mode
    always_comb begin
        src = rotated;
        unique case (mode)
            WM_DIRECT:      src = subst_bit ? fill : rotated;
            WM_EXPAND:      src = expanded;
            WM_MASKED_FILL: src = fill;
            WM_LATCH_COPY:  src = latch_byte;
        endcase
    end

    // Logic operation against the latch (modes 0 and 2 only)
    always_comb begin
        alu_out = src;
        if (mode == WM_DIRECT || mode == WM_EXPAND) begin
            unique case (lop)
                LOP_PASS: alu_out = src;
                LOP_AND:  alu_out = src & latch_byte;
                LOP_OR:   alu_out = src | latch_byte;
                LOP_XOR:  alu_out = src ^ latch_byte;
            endcase
        end
    end

    // Effective mask
    always_comb begin
        eff_mask = mask;
        unique case (mode)
            WM_DIRECT:      eff_mask = mask;
            WM_EXPAND:      eff_mask = mask;
            WM_MASKED_FILL: eff_mask = mask & rotated;
            WM_LATCH_COPY:  eff_mask = '0;
        endcase
    end

    assign plane_byte = (alu_out & eff_mask) | (latch_byte & ~eff_mask);

endmodule

// File: rtl/vpw_plane_ram.sv
module vpw_plane_ram
    import vpw_pkg::*;
#(
    parameter int ADDR_W = 6
)(
    input  logic                 clk,
    input  logic                 we,
    input  logic                 re,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [BYTE_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vplane_write_unit.sv
module vplane_write_unit
    import vpw_pkg::*;
#(
    parameter int ADDR_W = 6
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [7:0]            host_wdata,
    output logic [7:0]            host_rdata,
    output logic                  host_rvalid
);

    ctrl_t                               ctrl;
    acc_state_e                          state_q;
    acc_state_e                          state_d;
    logic [SEL_W-1:0]                    sel_q;
    logic                                ram_we;
    logic                                ram_re;
    logic                                latch_load;
    logic [NUM_PLANES-1:0][BYTE_W-1:0]   latch_bus;
    logic [NUM_PLANES-1:0][BYTE_W-1:0]   plane_wdata;
    logic [NUM_PLANES-1:0][BYTE_W-1:0]   plane_rdata;

    vpw_ctrl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && host_rd) begin
                sel_q <= ctrl.rdsel;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = host_rd ? ST_LOAD : ST_IDLE;
            ST_LOAD: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the access machine
    always_comb begin
        ram_we      = 1'b0;
        ram_re      = 1'b0;
        latch_load  = 1'b0;
        host_rvalid = 1'b0;
        host_rdata  = '0;
        unique case (state_q)
            ST_IDLE: begin
                ram_re = host_rd;
                ram_we = host_wr && !host_rd;
            end
            ST_LOAD: begin
                latch_load  = 1'b1;
                host_rvalid = 1'b1;
                host_rdata  = plane_rdata[sel_q];
            end
        endcase
    end

    // Latch registers: loaded only at the end of the load cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_bus <= '0;
        end else if (latch_load) begin
            latch_bus <= plane_rdata;
        end
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        vpw_plane_lane #(.PLANE(p)) u_lane (
            .mode       (ctrl.mode),
            .rot        (ctrl.rot),
            .lop        (ctrl.lop),
            .setres_bit (ctrl.setres[p]),
            .subst_bit  (ctrl.subst_en[p]),
            .mask       (ctrl.mask),
            .host_byte  (host_wdata),
            .latch_byte (latch_bus[p]),
            .plane_byte (plane_wdata[p])
        );

        vpw_plane_ram #(.ADDR_W(ADDR_W)) u_ram (
            .clk   (clk),
            .we    (ram_we),
            .re    (ram_re),
            .addr  (host_addr),
            .wdata (plane_wdata[p]),
            .rdata (plane_rdata[p])
        );
    end

endmodule

// File: rtl/vpw_checker.sv
module vpw_checker
    import vpw_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                host_wr,
    input  logic                                host_rd,
    input  logic                                host_rvalid,
    input  logic                                ram_we,
    input  ctrl_t                               ctrl,
    input  logic [NUM_PLANES-1:0][BYTE_W-1:0]   latch_bus,
    input  logic [NUM_PLANES-1:0][BYTE_W-1:0]   plane_wdata,
    input  logic [NUM_PLANES-1:0][BYTE_W-1:0]   plane_rdata
);

    AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid); // R10

    AST_NO_RVALID_WITHOUT_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid); // R10

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr)); // R10

    AST_NO_ACCESS_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_rd && !host_wr); // R10

    AST_LATCH_HOLDS_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rvalid |=> $stable(latch_bus)); // R11

    AST_LATCH_LOADS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> latch_bus == $past(plane_rdata)); // R9

    AST_COPY_MODE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && ctrl.mode == WM_LATCH_COPY |-> plane_wdata == latch_bus); // R2

    AST_ZERO_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we && ctrl.mode != WM_MASKED_FILL && ctrl.mask == '0 |-> plane_wdata == latch_bus); // R8

endmodule

bind vplane_write_unit vpw_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rvalid (host_rvalid),
    .ram_we      (ram_we),
    .ctrl        (ctrl),
    .latch_bus   (latch_bus),
    .plane_wdata (plane_wdata),
    .plane_rdata (plane_rdata)
);

// File: tb/vplane_write_unit_tb.sv
module vplane_write_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic          host_wr = 1'b0;
    logic          host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [7:0]    host_wdata = '0;
    logic [7:0]    host_rdata;
    logic          host_rvalid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench model state
    logic [7:0] mem_m [4][DEPTH];
    logic [7:0] lat_m [4];
    int m_mode = 0, m_rot = 0, m_lop = 0, m_sr = 0, m_en = 0, m_mask = 0, m_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vplane_write_unit #(.ADDR_W(AW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] ref_plane(int p, logic [7:0] d, logic [7:0] lat);
        logic [7:0] r, v, m, fill;
        r    = (d >> m_rot) | (d << (8 - m_rot));
        fill = m_sr[p] ? 8'hFF : 8'h00;
        m    = m_mask[7:0];
        if (m_mode == 1) return lat;
        if (m_mode == 3) begin
            v = fill;
            m = m & r;
        end else begin
            if (m_mode == 2)      v = d[p] ? 8'hFF : 8'h00;
            else if (m_en[p])     v = fill;
            else                  v = r;
            case (m_lop)
                1: v = v & lat;
                2: v = v | lat;
                3: v = v ^ lat;
                default: ;
            endcase
        end
        return (v & m) | (lat & ~m);
    endfunction

    task automatic cfg(int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            0: m_mode = d & 3;
            1: begin m_rot = d & 7; m_lop = (d >> 3) & 3; end
            2: m_sr = d & 15;
            3: m_en = d & 15;
            4: m_mask = d & 255;
            5: m_sel = d & 3;
            default: ;
        endcase
    endtask

    task automatic setup(int mode, int rot, int lop, int sr, int en, int mask);
        cfg(0, mode);
        cfg(1, (lop << 3) | rot);
        cfg(2, sr);
        cfg(3, en);
        cfg(4, mask);
    endtask

    task automatic hwrite(int a, logic [7:0] d);
        for (int p = 0; p < 4; p++) mem_m[p][a] = ref_plane(p, d, lat_m[p]);
        @(negedge clk);
        host_wr = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(int a, string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = AW'(a);
        @(negedge clk);
        host_rd = 1'b0;
        check({tag, " rvalid"}, {7'd0, host_rvalid}, 8'd1);
        check(tag, host_rdata, mem_m[m_sel][a]);
        for (int p = 0; p < 4; p++) lat_m[p] = mem_m[p][a];
        @(negedge clk);
        check({tag, " rvalid drop"}, {7'd0, host_rvalid}, 8'd0);
    endtask

    task automatic verify_addr(int a, string tag);
        for (int p = 0; p < 4; p++) begin
            cfg(5, p);
            hread(a, tag);
        end
    endtask

    // R1: reset values
    task automatic t_reset();
        check("R1 rvalid after reset", {7'd0, host_rvalid}, 8'd0);
        check("R1 rdata after reset", host_rdata, 8'h00);
        setup(1, 0, 0, 0, 0, 8'hFF);
        hwrite(5, 8'hA7);
        verify_addr(5, "R1 latch reset zero");
        check("R1 model latch", mem_m[2][5], 8'h00);
    endtask

    task automatic t_prefill();
        setup(0, 0, 0, 0, 0, 8'hFF);
        for (int a = 0; a < DEPTH; a++) hwrite(a, 8'(a * 37 + 11));
    endtask

    // R3: rotate
    task automatic t_rotate();
        setup(0, 3, 0, 0, 0, 8'hFF);
        hwrite(10, 8'h81);
        check("R3 model rot3", mem_m[0][10], 8'h30);
        verify_addr(10, "R3 rotate 3");
        setup(0, 0, 0, 0, 0, 8'hFF);
        hwrite(11, 8'hC5);
        verify_addr(11, "R3 rotate 0");
        setup(0, 7, 0, 0, 0, 8'hFF);
        hwrite(12, 8'h81);
        verify_addr(12, "R3 rotate 7");
    endtask

    // R4: expand
    task automatic t_expand();
        setup(2, 5, 0, 0, 0, 8'hFF);
        hwrite(13, 8'hF5);
        check("R4 model plane1", mem_m[1][13], 8'h00);
        verify_addr(13, "R4 expand");
    endtask

    // R5: set/reset substitution
    task automatic t_subst();
        setup(0, 0, 0, 4'b0100, 4'b0110, 8'hFF);
        hwrite(14, 8'h5A);
        verify_addr(14, "R5 substitute");
    endtask

    // R6: logic ops, modes 0 and 2
    task automatic t_logic();
        for (int op = 0; op < 4; op++) begin
            setup(0, 1, op, 0, 0, 8'hFF);
            hread(20 + op, "R6 latch load");
            hwrite(30 + op, 8'h6C);
            verify_addr(30 + op, "R6 mode0 op");
            setup(2, 0, op, 0, 0, 8'hFF);
            hread(21 + op, "R6 latch load");
            hwrite(36 + op, 8'h0B);
            verify_addr(36 + op, "R6 mode2 op");
        end
    endtask

    // R7: masked fill
    task automatic t_masked_fill();
        setup(3, 2, 3, 4'b1010, 4'b1111, 8'b1111_0000);
        hread(40, "R7 latch load");
        hwrite(41, 8'h3C);
        verify_addr(41, "R7 masked fill");
    endtask

    // R8: bit mask merge
    task automatic t_mask();
        setup(0, 0, 0, 0, 0, 8'h00);
        hread(42, "R8 latch load");
        hwrite(43, 8'hFF);
        verify_addr(43, "R8 mask zero mode0");
        setup(2, 0, 2, 0, 0, 8'h00);
        hread(44, "R8 latch load");
        hwrite(45, 8'h0F);
        verify_addr(45, "R8 mask zero mode2");
        setup(0, 0, 0, 0, 0, 8'h0F);
        hread(46, "R8 latch load");
        hwrite(47, 8'hAA);
        verify_addr(47, "R8 mask partial");
    endtask

    // R9 and R2: read loads all latches, copy mode stores them
    task automatic t_latch_copy();
        setup(0, 0, 0, 4'b0101, 4'b0011, 8'hFF);
        hwrite(48, 8'h99);
        hread(48, "R9 latch load");
        setup(1, 0, 0, 0, 0, 8'h00);
        hwrite(49, 8'h12);
        verify_addr(49, "R9 latch copy");
        hwrite(50, 8'hED);
        verify_addr(50, "R2 host data ignored");
    endtask

    // R10: read select per plane
    task automatic t_read_select();
        setup(2, 0, 0, 0, 0, 8'hFF);
        hwrite(51, 8'h06);
        verify_addr(51, "R10 read select");
    endtask

    // R11: write updates all planes, latches unchanged by writes
    task automatic t_write_no_latch();
        hread(52, "R11 latch load");
        setup(0, 0, 3, 0, 0, 8'hFF);
        hwrite(53, 8'hFF);
        verify_addr(53, "R11 all planes");
        hread(52, "R11 latch reload");
        setup(0, 0, 0, 0, 0, 8'hFF);
        hwrite(54, 8'h77);
        setup(1, 0, 0, 0, 0, 8'hFF);
        hwrite(55, 8'h00);
        verify_addr(55, "R11 latch kept after write");
    endtask

    // R12: register map, unmapped address ignored
    task automatic t_regmap();
        cfg(0, 8'hFC);
        cfg(1, 8'hE2);
        cfg(2, 8'hF0);
        cfg(3, 8'hF0);
        cfg(4, 8'hFF);
        cfg(6, 8'h01);
        hread(56, "R12 latch load");
        hwrite(57, 8'h0F);
        verify_addr(57, "R12 field positions");
    endtask

    task automatic t_random();
        for (int i = 0; i < 150; i++) begin
            setup(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 15)),
                  int'($urandom_range(0, 15)),
                  (i % 5 == 0) ? 0 : int'($urandom_range(0, 255)));
            cfg(5, int'($urandom_range(0, 3)));
            hread(int'($urandom_range(0, DEPTH - 1)), "R8 random latch");
            hwrite(int'($urandom_range(0, DEPTH - 1)), 8'($urandom));
            verify_addr(int'($urandom_range(0, DEPTH - 1)), "R8 random readback");
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        for (int p = 0; p < 4; p++) lat_m[p] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prefill();
        t_rotate();
        t_expand();
        t_subst();
        t_logic();
        t_masked_fill();
        t_mask();
        t_latch_copy();
        t_read_select();
        t_write_no_latch();
        t_regmap();
        t_random();
        done = 1'b1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

endmodule